// File: doc/BRIEF.md
# Dual-Mode Instruction Fetch Sequencer

This block sits at the front of a small long-word processor. Each cycle it reads one 64-bit word from an instruction memory and hands instructions to two consumers: an integer (core) pipe and a floating-point/graphics pipe. In single-issue mode it hands over one 32-bit instruction per cycle. A class bit in that instruction picks which pipe receives it. In dual-issue mode the whole 64-bit word goes out as a pair, with the core half and the float/graphics half issued in the same cycle.

The execution side resolves branches. It reports a branch in the same cycle in which the branching instruction is accepted. A branch is either immediate or has a single delay slot. For a delay-slot branch, the instruction that follows is still fetched and issued before control moves to the target. A second taken branch reported from inside a delay slot is an illegal condition. The sequencer discards it and raises a one-cycle fault flag.

Top module: `dual_issue_fetch`

## Requirements
- R1: While reset is held, no issue is valid, the program counter equals RESET_PC (0 by default), the mode is single and the fault flag is low. The first cycle after reset release issues nothing, and issuing begins on the following cycle.
- R2: In single mode, the 32-bit half of the fetched word selected by PC bit 2 (1 = bits 63:32, 0 = bits 31:0) is the instruction. Its bit 31 is the class (1 = float/graphics, 0 = core), and exactly one port, the one of that class, is valid and carries it.
- R3: In dual mode both ports are valid at once. The core port carries bits 31:0 and the float/graphics port carries bits 63:32, whatever their class bits.
- R4: An accepted issue advances the PC by 4 in single mode and by 8 in dual mode, unless a branch redirects it.
- R5: An issue is accepted only when every valid port is ready. In dual mode, one port not ready stalls both ports. While no issue is accepted, the PC and mode hold and branch reports are ignored.
- R6: The mode-select input is sampled only on an accepted issue and governs the next fetch. Dual mode is entered only when that next PC is a multiple of 8; otherwise that fetch is single.
- R7: An immediate branch reported with an accepted issue makes the next fetch address the branch target with bits 1:0 cleared.
- R8: A delay-slot branch makes the next fetch the sequential one (the slot), and the fetch after the slot goes to the target with bits 1:0 cleared.
- R9: A branch reported with the issue of a delay slot is ignored: the earlier branch's target is still taken, and the fault flag is high for exactly the next cycle.
- R10: The memory address output is the PC with bits 2:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_mode_i | input | 1 | Mode request: 1 = dual issue |
| imem_addr_o | output | AW | Byte address of the 64-bit fetch word |
| imem_data_i | input | 64 | Fetched word, same cycle as the address |
| issue_pc_o | output | AW | Byte address of the instruction(s) on offer |
| dual_active_o | output | 1 | Current offer is a dual pair |
| core_valid_o | output | 1 | Core port has an instruction |
| core_ready_i | input | 1 | Core pipe can accept |
| core_instr_o | output | 32 | Core instruction |
| fg_valid_o | output | 1 | Float/graphics port has an instruction |
| fg_ready_i | input | 1 | Float/graphics pipe can accept |
| fg_instr_o | output | 32 | Float/graphics instruction |
| br_req_i | input | 1 | Taken branch reported with this cycle's issue |
| br_delayed_i | input | 1 | Branch has a delay slot |
| br_target_i | input | AW | Branch target byte address |
| br_fault_o | output | 1 | Branch inside a delay slot was discarded |

## Verification
The properties assume that the execution side raises a branch report only for an instruction it is accepting in that cycle. Reports given during a stall are dropped, and the checks that follow an accepted issue rely on that. They also assume that the memory returns data in the same cycle for the presented address. The stimulus drives a combinational memory model whose words encode their own address and whose class bit follows address bit 4. Every branch report the stimulus gives is either paired with an accepted issue or presented deliberately during a stall.

// File: rtl/dif_pkg.sv
package dif_pkg;
    localparam int INSTR_W   = 32;
    localparam int FETCH_W   = 64;
    localparam int CLASS_BIT = INSTR_W - 1;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_DUAL   = 1'b1
    } issue_mode_e;
endpackage

// File: rtl/dif_route.sv
module dif_route
    import dif_pkg::*;
(
    input  logic               run_i,
    input  issue_mode_e        mode_i,
    input  logic               half_i,
    input  logic [FETCH_W-1:0] fetch_i,
    input  logic               core_ready_i,
    input  logic               fg_ready_i,
    output logic               core_valid_o,
    output logic               fg_valid_o,
    output logic [INSTR_W-1:0] core_instr_o,
    output logic [INSTR_W-1:0] fg_instr_o,
    output logic               fire_o
);
    localparam int HALVES = FETCH_W / INSTR_W;

    logic [INSTR_W-1:0] half_w [HALVES];
    logic [INSTR_W-1:0] pick_w;
    logic               is_fg;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_w[h] = fetch_i[h*INSTR_W +: INSTR_W];
    end

    always_comb begin
        pick_w = half_i ? half_w[1] : half_w[0];
        is_fg  = pick_w[CLASS_BIT];
        if (mode_i == MODE_DUAL) begin
            core_valid_o = run_i;
            fg_valid_o   = run_i;
            core_instr_o = half_w[0];
            fg_instr_o   = half_w[1];
            fire_o       = run_i & core_ready_i & fg_ready_i;
        end else begin
            core_valid_o = run_i & ~is_fg;
            fg_valid_o   = run_i & is_fg;
            core_instr_o = pick_w;
            fg_instr_o   = pick_w;
            fire_o       = (core_valid_o & core_ready_i) | (fg_valid_o & fg_ready_i);
        end
    end
endmodule

// File: rtl/dif_next.sv
module dif_next
    import dif_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          fire_i,
    input  logic [AW-1:0] pc_i,
    input  issue_mode_e   mode_i,
    input  logic          slot_i,
    input  logic [AW-1:0] slot_tgt_i,
    input  logic          dual_req_i,
    input  logic          br_req_i,
    input  logic          br_delayed_i,
    input  logic [AW-1:0] br_target_i,
    output logic [AW-1:0] pc_o,
    output issue_mode_e   mode_o,
    output logic          slot_o,
    output logic [AW-1:0] slot_tgt_o,
    output logic          fault_o
);
    localparam int STEP_S = INSTR_W / 8;
    localparam int STEP_D = FETCH_W / 8;
    localparam int SUB_W  = $clog2(STEP_S);
    localparam int PAIR_W = $clog2(STEP_D);

    logic [AW-1:0] seq_pc;
    logic [AW-1:0] tgt_al;
    logic [AW-1:0] nxt_pc;

    always_comb begin
        seq_pc = pc_i + ((mode_i == MODE_DUAL) ? AW'(STEP_D) : AW'(STEP_S));
        tgt_al = br_target_i;
        tgt_al[SUB_W-1:0] = '0;

        nxt_pc     = pc_i;
        mode_o     = mode_i;
        slot_o     = slot_i;
        slot_tgt_o = slot_tgt_i;
        fault_o    = 1'b0;

        if (fire_i) begin
            if (slot_i) begin
                nxt_pc  = slot_tgt_i;
                slot_o  = 1'b0;
                fault_o = br_req_i;
            end else if (br_req_i) begin
                if (br_delayed_i) begin
                    nxt_pc     = seq_pc;
                    slot_o     = 1'b1;
                    slot_tgt_o = tgt_al;
                end else begin
                    nxt_pc = tgt_al;
                end
            end else begin
                nxt_pc = seq_pc;
            end
            mode_o = (dual_req_i && (nxt_pc[PAIR_W-1:0] == '0)) ? MODE_DUAL : MODE_SINGLE;
        end
        pc_o = nxt_pc;
    end
endmodule

// File: rtl/dual_issue_fetch.sv
module dual_issue_fetch
    import dif_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dual_mode_i,
    output logic [AW-1:0]      imem_addr_o,
    input  logic [FETCH_W-1:0] imem_data_i,
    output logic [AW-1:0]      issue_pc_o,
    output logic               dual_active_o,
    output logic               core_valid_o,
    input  logic               core_ready_i,
    output logic [INSTR_W-1:0] core_instr_o,
    output logic               fg_valid_o,
    input  logic               fg_ready_i,
    output logic [INSTR_W-1:0] fg_instr_o,
    input  logic               br_req_i,
    input  logic               br_delayed_i,
    input  logic [AW-1:0]      br_target_i,
    output logic               br_fault_o
);
    localparam int WORD_OFF = $clog2(FETCH_W / 8);
    localparam int HALF_BIT = $clog2(INSTR_W / 8);

    typedef struct packed {
        logic          run;
        logic [AW-1:0] pc;
        issue_mode_e   mode;
        logic          slot;
        logic [AW-1:0] tgt;
        logic          fault;
    } fetch_state_t;

    fetch_state_t st_q, st_d;
    logic         fire;
    logic         slot_q;

    logic [AW-1:0] n_pc, n_tgt;
    issue_mode_e   n_mode;
    logic          n_slot, n_fault;

    dif_route u_route (
        .run_i        (st_q.run),
        .mode_i       (st_q.mode),
        .half_i       (st_q.pc[HALF_BIT]),
        .fetch_i      (imem_data_i),
        .core_ready_i (core_ready_i),
        .fg_ready_i   (fg_ready_i),
        .core_valid_o (core_valid_o),
        .fg_valid_o   (fg_valid_o),
        .core_instr_o (core_instr_o),
        .fg_instr_o   (fg_instr_o),
        .fire_o       (fire)
    );

    dif_next #(.AW(AW)) u_next (
        .fire_i       (fire),
        .pc_i         (st_q.pc),
        .mode_i       (st_q.mode),
        .slot_i       (st_q.slot),
        .slot_tgt_i   (st_q.tgt),
        .dual_req_i   (dual_mode_i),
        .br_req_i     (br_req_i),
        .br_delayed_i (br_delayed_i),
        .br_target_i  (br_target_i),
        .pc_o         (n_pc),
        .mode_o       (n_mode),
        .slot_o       (n_slot),
        .slot_tgt_o   (n_tgt),
        .fault_o      (n_fault)
    );

    always_comb begin
        st_d       = st_q;
        st_d.run   = 1'b1;
        st_d.pc    = n_pc;
        st_d.mode  = n_mode;
        st_d.slot  = n_slot;
        st_d.tgt   = n_tgt;
        st_d.fault = n_fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, pc: RESET_PC, mode: MODE_SINGLE,
                      slot: 1'b0, tgt: '0, fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        imem_addr_o = st_q.pc;
        imem_addr_o[WORD_OFF-1:0] = '0;
    end

    assign issue_pc_o    = st_q.pc;
    assign dual_active_o = (st_q.mode == MODE_DUAL);
    assign br_fault_o    = st_q.fault;
    assign slot_q        = st_q.slot;
endmodule

// File: rtl/dif_checker.sv
module dif_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] issue_pc_o,
    input logic          dual_active_o,
    input logic          core_valid_o,
    input logic          core_ready_i,
    input logic          fg_valid_o,
    input logic          fg_ready_i,
    input logic          br_req_i,
    input logic          br_delayed_i,
    input logic [AW-1:0] br_target_i,
    input logic          br_fault_o,
    input logic          slot_i
);
    logic          fire;
    logic [AW-1:0] tgt_al;

    assign fire = dual_active_o ? (core_valid_o & core_ready_i & fg_valid_o & fg_ready_i)
                                : ((core_valid_o & core_ready_i) | (fg_valid_o & fg_ready_i));
    assign tgt_al = {br_target_i[AW-1:2], 2'b00};

    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_active_o |-> $onehot0({core_valid_o, fg_valid_o}));

    p_pair_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dual_active_o |-> (core_valid_o && fg_valid_o));

    p_pair_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dual_active_o |-> (issue_pc_o[2:0] == 3'd0));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_valid_o || fg_valid_o) && !fire) |=> ($stable(issue_pc_o) && $stable(dual_active_o)));

    p_seq_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !br_req_i && !slot_i) |=>
            (issue_pc_o == $past(issue_pc_o) + ($past(dual_active_o) ? AW'(8) : AW'(4))));

    p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && br_req_i && !br_delayed_i && !slot_i) |=> (issue_pc_o == $past(tgt_al)));

    p_slot_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && br_req_i && br_delayed_i && !slot_i) |=> slot_i);

    p_fault_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_fault_o |-> $past(fire && br_req_i && slot_i));
endmodule

bind dual_issue_fetch dif_checker #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_pc_o    (issue_pc_o),
    .dual_active_o (dual_active_o),
    .core_valid_o  (core_valid_o),
    .core_ready_i  (core_ready_i),
    .fg_valid_o    (fg_valid_o),
    .fg_ready_i    (fg_ready_i),
    .br_req_i      (br_req_i),
    .br_delayed_i  (br_delayed_i),
    .br_target_i   (br_target_i),
    .br_fault_o    (br_fault_o),
    .slot_i        (slot_q)
);

// File: tb/dual_issue_fetch_bench.sv
module dual_issue_fetch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int NVEC       = 19;

    typedef struct packed {
        logic          dm;
        logic          cr;
        logic          fr;
        logic          br;
        logic          bd;
        logic [15:0]   tgt;
        logic [15:0]   epc;
        logic          ecv;
        logic          efv;
        logic          eda;
        logic          eflt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd0,  1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,1'b1,1'b0,1'b0,16'd0,   16'd4,  1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd4,  1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd8,  1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd12, 1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,16'd0,   16'd16, 1'b1,1'b1,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd16, 1'b1,1'b1,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,16'd64,  16'd24, 1'b1,1'b1,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b1,1'b1,16'd100, 16'd64, 1'b1,1'b1,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd72, 1'b1,1'b1,1'b1,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd100,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,16'd200, 16'd104,1'b1,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,16'd300, 16'd112,1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd200,1'b1,1'b0,1'b0,1'b1},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd204,1'b1,1'b0,1'b0,1'b0},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,16'd40,  16'd208,1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd208,1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b1,1'b0,16'd6,   16'd212,1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,   16'd4,  1'b1,1'b0,1'b0,1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dual_mode_i;
    logic [AW-1:0] imem_addr_o;
    logic [63:0]   imem_data_i;
    logic [AW-1:0] issue_pc_o;
    logic          dual_active_o;
    logic          core_valid_o, core_ready_i;
    logic [31:0]   core_instr_o;
    logic          fg_valid_o, fg_ready_i;
    logic [31:0]   fg_instr_o;
    logic          br_req_i, br_delayed_i;
    logic [AW-1:0] br_target_i;
    logic          br_fault_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: each word carries its own address; class bit = address bit 4
    function automatic logic [31:0] word_at(input logic [15:0] a);
        return {a[4], 15'd0, a};
    endfunction

    assign imem_data_i = {word_at(imem_addr_o + 16'd4), word_at(imem_addr_o)};

    dual_issue_fetch #(.AW(AW)) u_dual_issue_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .dual_mode_i   (dual_mode_i),
        .imem_addr_o   (imem_addr_o),
        .imem_data_i   (imem_data_i),
        .issue_pc_o    (issue_pc_o),
        .dual_active_o (dual_active_o),
        .core_valid_o  (core_valid_o),
        .core_ready_i  (core_ready_i),
        .core_instr_o  (core_instr_o),
        .fg_valid_o    (fg_valid_o),
        .fg_ready_i    (fg_ready_i),
        .fg_instr_o    (fg_instr_o),
        .br_req_i      (br_req_i),
        .br_delayed_i  (br_delayed_i),
        .br_target_i   (br_target_i),
        .br_fault_o    (br_fault_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_state(input string tag);
        chk({tag, " core_valid"}, 32'(core_valid_o), 32'd0);
        chk({tag, " fg_valid"},   32'(fg_valid_o),   32'd0);
        chk({tag, " pc"},         32'(issue_pc_o),   32'd0);
        chk({tag, " dual"},       32'(dual_active_o), 32'd0);
        chk({tag, " fault"},      32'(br_fault_o),   32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; dual_mode_i = 1'b1; core_ready_i = 1'b1; fg_ready_i = 1'b1;
        br_req_i = 1'b0; br_delayed_i = 1'b0; br_target_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_state("R1 in reset");
        dual_mode_i = 1'b0;
        rst_n = 1'b1;
        #1;
        idle_state("R1 first cycle");

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            dual_mode_i  = VECS[i].dm;
            core_ready_i = VECS[i].cr;
            fg_ready_i   = VECS[i].fr;
            br_req_i     = VECS[i].br;
            br_delayed_i = VECS[i].bd;
            br_target_i  = VECS[i].tgt;
            #1;
            chk($sformatf("R4 R5 R7 R8 pc v%0d", i), 32'(issue_pc_o), 32'(VECS[i].epc));
            chk($sformatf("R2 core_valid v%0d", i), 32'(core_valid_o), 32'(VECS[i].ecv));
            chk($sformatf("R2 fg_valid v%0d", i), 32'(fg_valid_o), 32'(VECS[i].efv));
            chk($sformatf("R6 dual v%0d", i), 32'(dual_active_o), 32'(VECS[i].eda));
            chk($sformatf("R9 fault v%0d", i), 32'(br_fault_o), 32'(VECS[i].eflt));
            chk($sformatf("R10 addr v%0d", i), 32'(imem_addr_o),
                32'({VECS[i].epc[15:3], 3'b000}));
            if (VECS[i].eda) begin
                chk($sformatf("R3 core half v%0d", i), core_instr_o, word_at(VECS[i].epc));
                chk($sformatf("R3 fg half v%0d", i), fg_instr_o, word_at(VECS[i].epc + 16'd4));
            end else if (VECS[i].ecv) begin
                chk($sformatf("R2 core instr v%0d", i), core_instr_o, word_at(VECS[i].epc));
            end else begin
                chk($sformatf("R2 fg instr v%0d", i), fg_instr_o, word_at(VECS[i].epc));
            end
        end

        // reset asserted in mid-run
        @(negedge clk);
        dual_mode_i = 1'b1; br_req_i = 1'b0;
        rst_n = 1'b0;
        #1;
        idle_state("R1 mid-run reset");
        chk("R10 addr in reset", 32'(imem_addr_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        dual_mode_i = 1'b0;
        #1;
        idle_state("R1 post-release idle");
        @(negedge clk);
        #1;
        chk("R1 issue resumes core_valid", 32'(core_valid_o), 32'd1);
        chk("R1 issue resumes pc", 32'(issue_pc_o), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule